// File: doc/BRIEF.md
# Floating-point exception status accumulator

This block keeps the floating-point control and status state for one execution unit. Each finished arithmetic operation reports a six-bit vector of raw exception indications. The block ORs that vector into sticky status bits. There is one sticky register for scalar operations and one for packed operations, and a per-operation select chooses which of the two receives the update. Software can clear both sticky registers with a one-cycle strobe.

A control register holds three fields: a per-flag mask, a precision selector and a rounding selector. The block compares the scalar flags with the mask. When a set flag is unmasked, the block raises both an error-summary bit and a busy bit in the scalar status word. The packed register carries flags only.

The block also decodes the control fields for the arithmetic datapath. The rounding mode goes out as a two-bit code. The precision goes out as a significand width. The reserved precision encoding is refused: the previous precision stays in effect and an illegal-configuration output is raised.

Top module: `fp_status_accum`

## Requirements
- R1: After reset, both sticky registers read zero and the error-summary, busy and illegal-configuration outputs are 0. The control register reads 0x0FF: all six mask bits set, precision 11, rounding 00. The significand width reads 64.
- R2: Flag bit positions, the same in both sticky registers and in the mask: [0] invalid, [1] denormal input, [2] divide-by-zero, [3] overflow, [4] underflow, [5] inexact. When `op_done` is high and `op_packed` is low, `op_flags` is ORed into `stat_rdata[5:0]` at the clock edge. An operation never clears a bit.
- R3: When `op_done` and `op_packed` are both high, `op_flags` is ORed into `pstat_rdata` and the scalar status is left unchanged. The packed register has no summary logic.
- R4: `stat_rdata[6]` (error summary) and `stat_rdata[7]` (busy) are both 1 exactly when some scalar flag is set while its mask bit is 0. A change of flags or mask shows in these bits from the next cycle.
- R5: A control write (`ctl_we`) loads the mask from `ctl_wdata[5:0]` and the rounding field from `ctl_wdata[9:8]`. `rnd_mode` gives that field: 0 round to nearest even, 1 round down, 2 round up, 3 round toward zero.
- R6: The precision field is `ctl_wdata[7:6]`. The encoding 00 selects single precision, shown as `sig_bits` 24. The encoding 10 selects double precision, shown as 53. The encoding 11 selects extended precision, shown as 64.
- R7: A control write with precision 01 leaves the previous precision in effect and sets `cfg_illegal`; the mask and rounding fields of that write still load. `cfg_illegal` stays set until the next control write with a legal precision.
- R8: `clr` zeroes both sticky registers, and with them the summary and busy bits. If an operation arrives in the same cycle, the register it targets ends up holding exactly that operation's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done | input | 1 | Operation-complete strobe |
| op_packed | input | 1 | The completed operation was packed |
| op_flags | input | 6 | Raw exception indications of the operation |
| clr | input | 1 | Software clear of the sticky state |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 10 | Control write data {rounding, precision, mask} |
| ctl_rdata | output | 10 | Control register read data |
| stat_rdata | output | 8 | Scalar status {busy, summary, flags} |
| pstat_rdata | output | 6 | Packed sticky flags |
| rnd_mode | output | 2 | Rounding mode for the datapath |
| sig_bits | output | 7 | Significand width of the selected precision |
| cfg_illegal | output | 1 | Last control write used the reserved precision |

## Verification
Assertions inside the block check several properties on every cycle: no scalar flag ever falls without a clear, and a packed update leaves the scalar status alone. They also check that a clear with a coincident operation leaves exactly that operation's flags, that a reserved precision write holds the old precision and raises the illegal flag, and that a raised summary persists while neither mask nor flags are touched. The bench scenarios are needed for the rest: the exact bit positions, the reset values, the encoding of each rounding and precision code, and the return of the summary when the mask is rewritten. The same applies to clearing the illegal flag with a later legal write.

// File: rtl/fp_status_accum.sv
module fp_status_accum #(
  parameter int SIG_SP = 24,
  parameter int SIG_DP = 53,
  parameter int SIG_XP = 64,
  parameter int SIGW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_done,
  input  logic            op_packed,
  input  logic [5:0]      op_flags,
  input  logic            clr,
  input  logic            ctl_we,
  input  logic [9:0]      ctl_wdata,
  output logic [9:0]      ctl_rdata,
  output logic [7:0]      stat_rdata,
  output logic [5:0]      pstat_rdata,
  output logic [1:0]      rnd_mode,
  output logic [SIGW-1:0] sig_bits,
  output logic            cfg_illegal
);
  localparam logic [1:0] PREC_SP  = 2'b00;
  localparam logic [1:0] PREC_RSV = 2'b01;
  localparam logic [1:0] PREC_DP  = 2'b10;
  localparam logic [1:0] PREC_XP  = 2'b11;

  logic [5:0] sflag_q, pflag_q, mask_q;
  logic [1:0] prec_q, rnd_q;
  logic       ill_q;

  wire s_upd  = op_done & ~op_packed;
  wire p_upd  = op_done & op_packed;
  wire wr_rsv = ctl_we & (ctl_wdata[7:6] == PREC_RSV);
  wire err    = |(sflag_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sflag_q <= '0;
      pflag_q <= '0;
      mask_q  <= '1;
      prec_q  <= PREC_XP;
      rnd_q   <= 2'b00;
      ill_q   <= 1'b0;
    end else begin
      if (clr) sflag_q <= s_upd ? op_flags : '0;
      else if (s_upd) sflag_q <= sflag_q | op_flags;
      if (clr) pflag_q <= p_upd ? op_flags : '0;
      else if (p_upd) pflag_q <= pflag_q | op_flags;
      if (ctl_we) begin
        mask_q <= ctl_wdata[5:0];
        rnd_q  <= ctl_wdata[9:8];
        ill_q  <= wr_rsv;
        if (!wr_rsv) prec_q <= ctl_wdata[7:6];
      end
    end
  end

  assign ctl_rdata   = {rnd_q, prec_q, mask_q};
  assign stat_rdata  = {err, err, sflag_q};
  assign pstat_rdata = pflag_q;
  assign rnd_mode    = rnd_q;
  assign cfg_illegal = ill_q;

  always_comb begin
    case (prec_q)
      PREC_SP: sig_bits = SIGW'(SIG_SP);
      PREC_DP: sig_bits = SIGW'(SIG_DP);
      default: sig_bits = SIGW'(SIG_XP);
    endcase
  end

  assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((stat_rdata[5:0] & $past(stat_rdata[5:0])) == $past(stat_rdata[5:0])));

  assert_packed_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_packed && !clr) |=> $stable(stat_rdata));

  assert_summary_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[6] && !clr && !ctl_we) |=> (stat_rdata[6] && stat_rdata[7]));

  assert_reserved_prec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[7:6] == 2'b01) |=> (cfg_illegal && ctl_rdata[7:6] == $past(ctl_rdata[7:6])));

  assert_clear_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && op_done && !op_packed) |=> (stat_rdata[5:0] == $past(op_flags) && pstat_rdata == 6'd0));

  always_comb begin
    if (rst_n) assert_prec_legal_R6: assert (ctl_rdata[7:6] != 2'b01);
  end
endmodule

// File: tb/fp_status_accum_tb_top.sv
module fp_status_accum_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_done = 1'b0, op_packed = 1'b0, clr = 1'b0, ctl_we = 1'b0;
  logic [5:0] op_flags = '0;
  logic [9:0] ctl_wdata = '0;
  logic [9:0] ctl_rdata;
  logic [7:0] stat_rdata;
  logic [5:0] pstat_rdata;
  logic [1:0] rnd_mode;
  logic [6:0] sig_bits;
  logic       cfg_illegal;

  always #2.5 clk = ~clk;

  fp_status_accum dut_i (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_packed(op_packed),
    .op_flags(op_flags), .clr(clr), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata), .pstat_rdata(pstat_rdata),
    .rnd_mode(rnd_mode), .sig_bits(sig_bits), .cfg_illegal(cfg_illegal)
  );

  typedef struct {
    string      tag;
    logic [9:0] ctl;
    logic [7:0] st;
    logic [5:0] pst;
    logic [1:0] rnd;
    logic [6:0] sig;
    logic       ill;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [5:0] m_sf = '0, m_pf = '0, m_mask = '1;
  logic [1:0] m_prec = 2'b11, m_rnd = 2'b00;
  logic       m_ill = 1'b0;

  function automatic logic [6:0] width_of(logic [1:0] p);
    if (p == 2'b00) return 7'd24;
    if (p == 2'b10) return 7'd53;
    return 7'd64;
  endfunction

  task automatic push(string tag);
    exp_t e;
    logic er;
    er = |(m_sf & ~m_mask);
    e.tag = tag;
    e.ctl = {m_rnd, m_prec, m_mask};
    e.st = {er, er, m_sf};
    e.pst = m_pf;
    e.rnd = m_rnd;
    e.sig = width_of(m_prec);
    e.ill = m_ill;
    q.push_back(e);
  endtask

  task automatic step(input logic d, input logic pk, input logic [5:0] f,
                      input logic c, input logic w, input logic [9:0] wd, input string tag);
    @(negedge clk);
    op_done = d; op_packed = pk; op_flags = f; clr = c; ctl_we = w; ctl_wdata = wd;
    if (c) begin
      m_sf = (d && !pk) ? f : 6'd0;
      m_pf = (d && pk) ? f : 6'd0;
    end else if (d) begin
      if (pk) m_pf = m_pf | f; else m_sf = m_sf | f;
    end
    if (w) begin
      m_mask = wd[5:0];
      m_rnd = wd[9:8];
      m_ill = (wd[7:6] == 2'b01);
      if (wd[7:6] != 2'b01) m_prec = wd[7:6];
    end
    @(negedge clk);
    op_done = 0; op_packed = 0; op_flags = '0; clr = 0; ctl_we = 0;
    push(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ctl_rdata !== e.ctl || stat_rdata !== e.st || pstat_rdata !== e.pst ||
            rnd_mode !== e.rnd || sig_bits !== e.sig || cfg_illegal !== e.ill) begin
          fails++;
          $display("FAIL %s: actual ctl=%h st=%h pst=%h rnd=%0d sig=%0d ill=%b expected ctl=%h st=%h pst=%h rnd=%0d sig=%0d ill=%b",
                   e.tag, ctl_rdata, stat_rdata, pstat_rdata, rnd_mode, sig_bits, cfg_illegal,
                   e.ctl, e.st, e.pst, e.rnd, e.sig, e.ill);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    push("R1 reset state");
    step(1, 0, 6'h01, 0, 0, '0, "R2 invalid into scalar");
    step(1, 0, 6'h08, 0, 0, '0, "R2 overflow accumulates");
    step(1, 0, 6'h00, 0, 0, '0, "R2 empty op keeps bits");
    step(1, 1, 6'h20, 0, 0, '0, "R3 packed inexact only");
    step(0, 0, '0, 0, 1, {2'b00, 2'b11, 6'h37}, "R4 unmask overflow raises summary");
    step(0, 0, '0, 0, 1, {2'b01, 2'b10, 6'h3F}, "R5 round down R6 double");
    step(0, 0, '0, 0, 1, {2'b10, 2'b10, 6'h3F}, "R5 round up");
    step(0, 0, '0, 0, 1, {2'b11, 2'b00, 6'h3F}, "R5 toward zero R6 single");
    step(0, 0, '0, 0, 1, {2'b10, 2'b01, 6'h3E}, "R7 reserved precision rejected");
    step(1, 0, 6'h10, 0, 0, '0, "R7 illegal flag holds R4 summary stays");
    step(0, 0, '0, 0, 1, {2'b00, 2'b11, 6'h3F}, "R7 legal write clears illegal");
    step(0, 0, '0, 1, 0, '0, "R8 clear both registers");
    step(1, 0, 6'h04, 1, 0, '0, "R8 clear with scalar update");
    step(1, 1, 6'h02, 1, 0, '0, "R8 clear with packed update");
    step(0, 0, '0, 0, 1, {2'b00, 2'b11, 6'h00}, "R4 scalar empty no summary");
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule